// File: doc/BRIEF.md
# Hybrid Local/Global Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two independent direction predictors and a per-context chooser between them. The global side keeps a shift register of the most recent resolved outcomes. That register indexes a table of 2-bit saturating counters. The local side is two-level. Address bits of the branch select an entry in a table of per-branch outcome histories, and that history indexes a table of 3-bit saturating counters. A table of 2-bit chooser counters, also indexed by the global history, decides which side supplies the final answer.

The fetch side presents a PC on the predict port. In the same cycle it gets back the final direction, which side was chosen, both component directions and the current global history. When the branch resolves, the back end presents the PC, the real outcome and the two component directions it was given, on the update port. Every resolved branch trains both component counters and shifts both histories. The chooser moves only when the two sides disagreed. Table sizes are parameters. The defaults are a reduced configuration. Setting `GH_W=12`, `LH_W=10`, `LT_W=10` gives the full arrangement: 4K global counters, 4K chooser counters, 1K ten-bit histories and 1K three-bit counters, about 29K bits in total.

Top module: `tourney_bp`

## Requirements
- R1: After reset, every 2-bit counter holds 1, every 3-bit counter holds 3, and all histories are zero. So for any PC, `pred_taken`, `pred_local`, `pred_global` and `pred_use_global` are 0, and `ghist_o` is 0.
- R2: On each cycle with `upd_valid`=1, the global history shifts left by one and takes `upd_taken` into bit 0, so bit i holds the outcome of the i-th prior resolved branch (1 = taken). Without `upd_valid` the history does not change.
- R3: `pred_global` is bit 1 of the 2-bit counter addressed by the current global history, so it is taken for values 2 and 3. Each update moves that counter one step toward the outcome, saturating at 0 and 3.
- R4: The local history entry is selected by `pred_pc[LT_W+1:2]` (or `upd_pc[LT_W+1:2]` on update). Each update shifts that entry left and takes the outcome into bit 0.
- R5: `pred_local` is bit 2 of the 3-bit counter addressed by the selected local history, so it is taken for values 4 to 7. Each update moves that counter one step toward the outcome, saturating at 0 and 7.
- R6: The chooser counter addressed by the global history selects the global side when its value is 2 or 3 (`pred_use_global`=1) and the local side otherwise. `pred_taken` equals the selected component's direction.
- R7: The chooser counter changes only when `upd_local` differs from `upd_global`. It then steps up if `upd_global` matches the outcome and down otherwise, saturating at 0 and 3.
- R8: Predict outputs in a cycle that also carries an update reflect the state before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | PC of the branch being predicted |
| pred_taken | output | 1 | Final direction (1 = taken) |
| pred_use_global | output | 1 | 1 when the global side was chosen |
| pred_local | output | 1 | Local component direction |
| pred_global | output | 1 | Global component direction |
| ghist_o | output | GH_W | Current global outcome history, bit 0 newest |
| upd_valid | input | 1 | A branch has resolved this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_local | input | 1 | Local direction returned at predict time |
| upd_global | input | 1 | Global direction returned at predict time |

## Verification
A wrong global history shows on `ghist_o` one cycle after the faulty update. It also shifts which global and chooser counters are read, so `pred_global` and `pred_use_global` diverge from a reference within a few branches. Corruption in the local history or counters stays hidden until that branch's PC is presented again. The bench therefore revisits the same addresses over and over, so each fault surfaces on the next visit. A counter that fails to saturate shows only after a long one-directional run followed by a single opposite outcome, and dedicated scenarios drive exactly that.

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int PC_W = 32,
  parameter int GH_W = 8,
  parameter int LH_W = 6,
  parameter int LT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_use_global,
  output logic            pred_local,
  output logic            pred_global,
  output logic [GH_W-1:0] ghist_o,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local,
  input  logic            upd_global
);
  localparam int GN = 1 << GH_W;
  localparam int LN = 1 << LT_W;
  localparam int CN = 1 << LH_W;

  logic [GH_W-1:0] ghist;
  logic [1:0]      gctr [GN];
  logic [1:0]      chsr [GN];
  logic [LH_W-1:0] lhist [LN];
  logic [2:0]      lctr [CN];

  function automatic logic [1:0] step2(input logic [1:0] v, input logic up);
    if (up) return (v == 2'd3) ? v : v + 2'd1;
    else    return (v == 2'd0) ? v : v - 2'd1;
  endfunction

  function automatic logic [2:0] step3(input logic [2:0] v, input logic up);
    if (up) return (v == 3'd7) ? v : v + 3'd1;
    else    return (v == 3'd0) ? v : v - 3'd1;
  endfunction

  // predict path
  wire [LT_W-1:0] p_idx = pred_pc[LT_W+1:2];
  wire [LH_W-1:0] p_lh  = lhist[p_idx];
  wire [1:0]      p_ch  = chsr[ghist];

  assign pred_local      = lctr[p_lh][2];
  assign pred_global     = gctr[ghist][1];
  assign pred_use_global = p_ch[1];
  assign pred_taken      = pred_use_global ? pred_global : pred_local;
  assign ghist_o         = ghist;

  // update path
  wire [LT_W-1:0] u_idx = upd_pc[LT_W+1:2];
  wire [LH_W-1:0] u_lh  = lhist[u_idx];
  wire [1:0]      u_g   = gctr[ghist];
  wire [2:0]      u_l   = lctr[u_lh];
  wire [1:0]      u_c   = chsr[ghist];
  wire            u_dis = upd_local != upd_global;

  always_ff @(posedge clk) begin
    if (!rst_n) ghist <= '0;
    else if (upd_valid) ghist <= {ghist[GH_W-2:0], upd_taken};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < GN; i++) begin
        gctr[i] <= 2'd1;
        chsr[i] <= 2'd1;
      end
    end else if (upd_valid) begin
      gctr[ghist] <= step2(u_g, upd_taken);
      if (u_dis) chsr[ghist] <= step2(u_c, upd_global == upd_taken);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LN; i++) lhist[i] <= '0;
    end else if (upd_valid) begin
      lhist[u_idx] <= {u_lh[LH_W-2:0], upd_taken};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CN; i++) lctr[i] <= 3'd3;
    end else if (upd_valid) begin
      lctr[u_lh] <= step3(u_l, upd_taken);
    end
  end

  // assertions
  logic            past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  assert_ghist_shift_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(upd_valid) |-> (ghist[0] == $past(upd_taken)) &&
                         (ghist[GH_W-1:1] == $past(ghist[GH_W-2:0])));

  assert_ghist_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !$past(upd_valid) |-> $stable(ghist));

  assert_gctr_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && u_g == 2'd3) |=> gctr[$past(ghist)] == 2'd3);

  assert_lhist_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> lhist[$past(u_idx)][0] == $past(upd_taken));

  assert_lctr_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && u_l == 3'd0) |=> lctr[$past(u_lh)] == 3'd0);

  assert_chsr_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !u_dis) |=> chsr[$past(ghist)] == $past(u_c));
endmodule

// File: tb/sim_tourney_bp.sv
module sim_tourney_bp;
  localparam int PC_W = 32, GH_W = 8, LH_W = 6, LT_W = 6;
  localparam int GN = 1 << GH_W, LN = 1 << LT_W, CN = 1 << LH_W;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic upd_valid = 0, upd_taken = 0, upd_local = 0, upd_global = 0;
  logic pred_taken, pred_use_global, pred_local, pred_global;
  logic [GH_W-1:0] ghist_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  tourney_bp #(.PC_W(PC_W), .GH_W(GH_W), .LH_W(LH_W), .LT_W(LT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_use_global(pred_use_global), .pred_local(pred_local),
    .pred_global(pred_global), .ghist_o(ghist_o), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_local(upd_local),
    .upd_global(upd_global));

  // reference state built from the requirements
  logic [GH_W-1:0] m_gh;
  logic [1:0] m_g [GN];
  logic [1:0] m_c [GN];
  logic [LH_W-1:0] m_lh [LN];
  logic [2:0] m_l [CN];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_gh = '0;
    for (int i = 0; i < GN; i++) begin m_g[i] = 2'd1; m_c[i] = 2'd1; end
    for (int i = 0; i < LN; i++) m_lh[i] = '0;
    for (int i = 0; i < CN; i++) m_l[i] = 3'd3;
  endtask

  function automatic logic m_lp(input logic [PC_W-1:0] pc);
    return m_l[m_lh[pc[LT_W+1:2]]] >= 3'd4;
  endfunction
  function automatic logic m_gp();
    return m_g[m_gh] >= 2'd2;
  endfunction

  task automatic compare(input logic [PC_W-1:0] pc);
    logic lp, gp, ug;
    lp = m_lp(pc); gp = m_gp(); ug = m_c[m_gh] >= 2'd2;
    chk("R5 local", pred_local, lp);
    chk("R3 global", pred_global, gp);
    chk("R6 chooser", pred_use_global, ug);
    chk("R6 final", pred_taken, ug ? gp : lp);
    chk("R2 ghist", ghist_o, m_gh);
  endtask

  // one branch: predict, check, resolve in the same cycle (R8)
  task automatic branch(input logic [PC_W-1:0] pc, input logic t);
    logic lp, gp;
    logic [LT_W-1:0] ix;
    @(negedge clk);
    pred_pc = pc;
    #1;
    compare(pc);
    lp = m_lp(pc); gp = m_gp();
    upd_valid = 1; upd_pc = pc; upd_taken = t; upd_local = lp; upd_global = gp;
    #1;
    // R8: outputs still show pre-update state while the update is pending
    chk("R8 pre-update", {pred_local, pred_global}, {lp, gp});
    @(posedge clk);
    #1;
    upd_valid = 0;
    ix = pc[LT_W+1:2];
    if (t) m_g[m_gh] = (m_g[m_gh] == 3) ? 2'd3 : m_g[m_gh] + 2'd1;
    else   m_g[m_gh] = (m_g[m_gh] == 0) ? 2'd0 : m_g[m_gh] - 2'd1;
    if (lp != gp) begin
      if (gp == t) m_c[m_gh] = (m_c[m_gh] == 3) ? 2'd3 : m_c[m_gh] + 2'd1;
      else         m_c[m_gh] = (m_c[m_gh] == 0) ? 2'd0 : m_c[m_gh] - 2'd1;
    end
    if (t) m_l[m_lh[ix]] = (m_l[m_lh[ix]] == 7) ? 3'd7 : m_l[m_lh[ix]] + 3'd1;
    else   m_l[m_lh[ix]] = (m_l[m_lh[ix]] == 0) ? 3'd0 : m_l[m_lh[ix]] - 3'd1;
    m_lh[ix] = {m_lh[ix][LH_W-2:0], t};
    m_gh = {m_gh[GH_W-2:0], t};
  endtask

  task automatic do_reset();
    rst_n = 0; upd_valid = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    m_reset();
  endtask

  task automatic t_reset();
    do_reset();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); pred_pc = 32'h1000 + 32'(k * 52);
      #1;
      chk("R1 taken", pred_taken, 0);
      chk("R1 local", pred_local, 0);
      chk("R1 global", pred_global, 0);
      chk("R1 chooser", pred_use_global, 0);
      chk("R1 ghist", ghist_o, 0);
    end
  endtask

  task automatic t_always_taken();
    do_reset();
    for (int k = 0; k < 40; k++) branch(32'h2040, 1'b1);
    @(negedge clk); pred_pc = 32'h2040; #1;
    chk("R2 all-ones", ghist_o, {GH_W{1'b1}});
    chk("R3 saturated taken", pred_global, 1);
    chk("R5 saturated taken", pred_local, 1);
    // one opposite outcome must not flip saturated counters (R3, R5)
    branch(32'h2040, 1'b0);
    @(negedge clk); #1;
    chk("R2 newest bit", ghist_o[0], 0);
  endtask

  task automatic t_never_taken();
    do_reset();
    for (int k = 0; k < 30; k++) branch(32'h3000, 1'b0);
    @(negedge clk); pred_pc = 32'h3000; #1;
    chk("R3 floor", pred_global, 0);
    chk("R5 floor", pred_local, 0);
    chk("R2 zeros", ghist_o, 0);
    branch(32'h3000, 1'b1);
    branch(32'h3000, 1'b0);
  endtask

  task automatic t_alternate();
    do_reset();
    for (int k = 0; k < 60; k++) branch(32'h4008, 1'(k & 1));
    @(negedge clk); pred_pc = 32'h4008; #1;
    chk("R4 learned pattern", pred_local, 0);
  endtask

  task automatic t_idle();
    logic [GH_W-1:0] g;
    do_reset();
    branch(32'h5000, 1); branch(32'h5004, 0); branch(32'h5000, 1);
    @(negedge clk); #1; g = ghist_o;
    repeat (5) @(posedge clk);
    @(negedge clk); pred_pc = 32'h5000; #1;
    chk("R2 hold", ghist_o, g);
    compare(32'h5000);
  endtask

  task automatic t_mixed();
    logic [15:0] lf = 16'hACE1;
    do_reset();
    for (int k = 0; k < 800; k++) begin
      logic [2:0] sel;
      logic t;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sel = lf[2:0];
      // site 0 loop-like, site 1 follows previous outcome, others noisy
      case (sel[1:0])
        2'd0: t = (k % 7) != 6;
        2'd1: t = m_gh[0];
        default: t = lf[5];
      endcase
      branch(32'h8000 + {26'd0, sel, 2'b00} + {20'd0, sel[2], 11'd0}, t);
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_always_taken();
        t_never_taken();
        t_alternate();
        t_idle();
        t_mixed();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule